// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial EEPROM Device Model

This block is a synthesizable device-side model of a 128-word by 16-bit serial non-volatile memory. A controller reaches it through a four-wire slave port: an active-high select, a serial clock, a serial data input and a serial data output with a separate output enable. The block samples select, clock and data with the system clock through a short synchronizer and acts on detected edges. The storage is a register file. The self-timed program interval is a count of system clocks.

A command starts with a 1 bit. A 2-bit opcode follows, then an 8-bit address field, and for the two data-loading commands a 16-bit data word. Reads return a leading 0 and then the word, most significant bit first. Program commands need the write-enable latch to be set. Each one starts its program interval when select falls. While the interval runs and select is high, the output reports busy (0). When the interval ends it reports ready (1), and this status stays until a start bit is clocked in.

Controller states: IDLE waits for a start bit. OPC collects the opcode. ADR collects the address. DAT collects the data word. RDOUT shifts read data out. ARMED waits for select to fall. HOLD waits for select low after a cancelled command. BUSY runs the program interval. RDY reports ready. The transitions are as follows. IDLE goes to OPC on a start bit. OPC goes to ADR after two bits. ADR goes to RDOUT for a read, to DAT for the two data-loading commands, and to ARMED for all others. DAT goes to ARMED after 16 bits. ARMED goes to BUSY on select fall when a program command is enabled, to IDLE on select fall in any other case, and to HOLD on an extra clock. BUSY goes to RDY when the counter expires. RDY goes to OPC on a start bit. A select fall returns OPC, ADR, DAT, RDOUT and HOLD to IDLE.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, and every word reads as 16'hFFFF.
- R2: Any number of 0 bits clocked in while select is high before the first 1 is ignored. That first 1 begins the command.
- R3: Opcode 2'b10 reads. On the clock rise that latches the last address bit, the output drives 0. The next 16 rises give bits 15 down to 0 of the word selected by the low 7 address bits. The address MSB is ignored, and the read works whether writes are enabled or not.
- R4: Opcode 2'b00 with address MSBs 2'b11 sets the write-enable latch, and with MSBs 2'b00 clears it. Either change happens only when select falls.
- R5: Opcode 2'b01 with 16 data bits (bit 15 first) programs the addressed word. The address MSB is ignored.
- R6: Opcode 2'b11 sets the addressed word to 16'hFFFF.
- R7: Opcode 2'b00 with address MSBs 2'b01 loads the data word into every location. With MSBs 2'b10 it sets every location to 16'hFFFF.
- R8: A program command issued while the latch is clear changes no word, and it starts no busy interval: the output enable stays low when select is raised again.
- R9: After an enabled program command, select falling starts an interval of PROG_CYCLES system clocks. With select high, the output is driven 0 during the interval and 1 after it. Toggling select does not affect the interval.
- R10: The ready status stays on across select toggles and 0 bits. A clocked 1 returns the output to high impedance and is taken as the start bit of the next command.
- R11: Clock and data activity during the busy interval is ignored: no command is decoded or executed.
- R12: A clock rise after the last required bit and before select falls cancels the command, including a write-enable command.
- R13: The output enable is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the controller |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data / ready-busy out |
| do_oe | output | 1 | Output enable for do_o |

## Verification
Each input passes through two synchronizer flops, and the state updates on the edge after that. So the output responds to a clock rise or a select change three system clocks after the pin changes. The bench holds every serial clock phase for three system-clock periods and samples one falling edge after that response. Program results are due PROG_CYCLES clocks after the detected select fall. The bench therefore checks busy a few clocks after raising select, and checks ready or reads back only after PROG_CYCLES plus a margin.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RDOUT,
        ST_ARMED, ST_HOLD, ST_BUSY, ST_RDY
    } mw_state_t;

    typedef enum logic [2:0] {
        CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN, CMD_WDS, CMD_WRAL, CMD_ERAL
    } mw_cmd_t;

    // opcode 00 is split further by the two address MSBs
    function automatic mw_cmd_t mw_decode(input logic [1:0] opc, input logic [1:0] top);
        mw_cmd_t c;
        unique case (opc)
            2'b10: c = CMD_READ;
            2'b01: c = CMD_WRITE;
            2'b11: c = CMD_ERASE;
            default: begin
                unique case (top)
                    2'b11: c = CMD_WEN;
                    2'b01: c = CMD_WRAL;
                    2'b10: c = CMD_ERAL;
                    default: c = CMD_WDS;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic mw_is_prog(input mw_cmd_t c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRAL) || (c == CMD_ERAL);
    endfunction

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_q,
    output logic di_q,
    output logic sk_rise,
    output logic cs_fall
);
    logic [2:0] stg [SYNC_STAGES];
    logic [1:0] prev_q;
    logic       sk_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= {cs_i, sk_i, di_i};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= {cs_q, sk_now};
        end
    end

    assign cs_q    = stg[SYNC_STAGES-1][2];
    assign sk_now  = stg[SYNC_STAGES-1][1];
    assign di_q    = stg[SYNC_STAGES-1][0];
    assign sk_rise = sk_now & ~prev_q[0];
    assign cs_fall = ~cs_q & prev_q[1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
    parameter int WORDS = 128,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_one,
    input  logic             wr_all,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[w] <= '1;
            else if (wr_all || (wr_one && waddr == IDX_W'(w)))
                mem[w] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_single_write_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_all, wr_one}));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORDS       = 128,
    parameter int WIDTH       = 16,
    parameter int ADDR_FIELD  = 8,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = $clog2(WIDTH + ADDR_FIELD);

    logic cs_q, di_q, sk_rise, cs_fall, clk_in;
    logic tmr_start, tmr_busy, tmr_done;
    logic wr_one, wr_all;
    logic [WIDTH-1:0] wdata, rdata;

    mw_state_t state_q, state_d;
    mw_cmd_t   cmd_q, cmd_new;
    logic [CNT_W-1:0]      cnt_q;
    logic [1:0]            opc_q;
    logic [ADDR_FIELD-2:0] adr_q;
    logic [ADDR_FIELD-1:0] adr_full;
    logic [WIDTH-1:0]      dat_q;
    logic [WIDTH:0]        rd_sr;
    logic                  we_q;

    mw_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(tmr_busy), .done(tmr_done)
    );

    mw_regfile #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_one(wr_one), .wr_all(wr_all),
        .waddr(adr_q[IDX_W-1:0]), .wdata(wdata),
        .raddr(adr_full[IDX_W-1:0]), .rdata(rdata)
    );

    assign clk_in   = sk_rise & cs_q;
    assign adr_full = {adr_q, di_q};
    assign cmd_new  = mw_decode(opc_q, adr_full[ADDR_FIELD-1 -: 2]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (clk_in && di_q) state_d = ST_OPC;
            ST_OPC:   if (cs_fall) state_d = ST_IDLE;
                      else if (clk_in && cnt_q == CNT_W'(1)) state_d = ST_ADR;
            ST_ADR:   if (cs_fall) state_d = ST_IDLE;
                      else if (clk_in && cnt_q == CNT_W'(ADDR_FIELD-1)) begin
                          if (cmd_new == CMD_READ) state_d = ST_RDOUT;
                          else if (cmd_new == CMD_WRITE || cmd_new == CMD_WRAL) state_d = ST_DAT;
                          else state_d = ST_ARMED;
                      end
            ST_DAT:   if (cs_fall) state_d = ST_IDLE;
                      else if (clk_in && cnt_q == CNT_W'(WIDTH-1)) state_d = ST_ARMED;
            ST_RDOUT: if (cs_fall) state_d = ST_IDLE;
            ST_ARMED: if (cs_fall) state_d = (mw_is_prog(cmd_q) && we_q) ? ST_BUSY : ST_IDLE;
                      else if (clk_in) state_d = ST_HOLD;
            ST_HOLD:  if (cs_fall) state_d = ST_IDLE;
            ST_BUSY:  if (tmr_done) state_d = ST_RDY;
            ST_RDY:   if (clk_in && di_q) state_d = ST_OPC;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            opc_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
            rd_sr <= '0;
            cmd_q <= CMD_WDS;
            we_q  <= 1'b0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (clk_in && (state_q == ST_OPC || state_q == ST_ADR || state_q == ST_DAT))
                cnt_q <= cnt_q + 1'b1;
            if (clk_in) begin
                unique case (state_q)
                    ST_OPC: opc_q <= {opc_q[0], di_q};
                    ST_ADR: begin
                        adr_q <= adr_full[ADDR_FIELD-2:0];
                        if (cnt_q == CNT_W'(ADDR_FIELD-1)) begin
                            cmd_q <= cmd_new;
                            rd_sr <= {1'b0, rdata};
                        end
                    end
                    ST_DAT:   dat_q <= {dat_q[WIDTH-2:0], di_q};
                    ST_RDOUT: rd_sr <= {rd_sr[WIDTH-1:0], 1'b0};
                    default: ;
                endcase
            end
            if (state_q == ST_ARMED && cs_fall) begin
                if (cmd_q == CMD_WEN)      we_q <= 1'b1;
                else if (cmd_q == CMD_WDS) we_q <= 1'b0;
            end
        end
    end

    assign tmr_start = (state_q == ST_ARMED) && (state_d == ST_BUSY);
    assign wr_one = (state_q == ST_BUSY) && tmr_done && (cmd_q == CMD_WRITE || cmd_q == CMD_ERASE);
    assign wr_all = (state_q == ST_BUSY) && tmr_done && (cmd_q == CMD_WRAL || cmd_q == CMD_ERAL);
    assign wdata  = (cmd_q == CMD_ERASE || cmd_q == CMD_ERAL) ? '1 : dat_q;

    // outputs
    always_comb begin
        do_oe = 1'b0;
        do_o  = 1'b0;
        unique case (state_q)
            ST_RDOUT: begin do_oe = cs_q; do_o = rd_sr[WIDTH]; end
            ST_BUSY:  begin do_oe = cs_q; do_o = 1'b0; end
            ST_RDY:   begin do_oe = cs_q; do_o = 1'b1; end
            default: ;
        endcase
    end

    assert_done_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> state_q == ST_BUSY);
    assert_busy_after_cs_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> $past(cs_fall));
    assert_we_on_cs_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(we_q) |-> $past(cs_fall));
    assert_hiz_deselect_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_q |-> !do_oe);
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    int n_chk = 0, n_fail = 0;
    logic last_oe;

    always #2.5 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(do_o), .do_oe(do_oe)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 40503) ^ 16'h2C5A;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b, output logic r);
        @(negedge clk); sk = 1'b0; di = b;
        wait_n(3);
        sk = 1'b1;
        wait_n(3);
        r = do_o; last_oe = do_oe;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic r;
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i], r);
    endtask

    task automatic cs_up();
        @(negedge clk); cs = 1'b1; wait_n(3);
    endtask

    task automatic cs_down();
        @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0; wait_n(3);
    endtask

    // read; when first is 0 the select is already high and the start bit was sent
    task automatic rd(input logic [7:0] a, input logic first, output logic [16:0] got);
        logic r;
        if (first) begin cs_up(); sk_bit(1'b1, r); end
        send({30'd0, 2'b10}, 2);
        send({25'd0, a[7:1]}, 7);
        sk_bit(a[0], r); got[16] = r;
        for (int i = 15; i >= 0; i--) begin sk_bit(1'b0, r); got[i] = r; end
        cs_down();
    endtask

    task automatic prog(input logic [1:0] opc, input logic [7:0] a, input logic [15:0] d,
                        input logic has_data, input logic extra);
        logic r;
        cs_up();
        send({21'd0, 1'b1, opc, a}, 11);
        if (has_data) send({16'd0, d}, 16);
        if (extra) sk_bit(1'b0, r);
        cs_down();
    endtask

    task automatic chk_word(input logic [7:0] a, input logic [15:0] exp, input string req);
        logic [16:0] got;
        rd(a, 1'b1, got);
        check(got == {1'b0, exp}, req, 32'(got), 32'({1'b0, exp}));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic r;
        logic [16:0] got;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        check(do_oe == 1'b0, "R1 oe after reset", 32'(do_oe), 0);
        chk_word(8'h00, 16'hFFFF, "R1 initial word");

        // R2: leading zeros then start bit
        cs_up();
        send(32'h0, 3);
        sk_bit(1'b1, r);
        rd(8'h12, 1'b0, got);
        check(got == 17'h0FFFF, "R2 leading zeros", 32'(got), 32'h0FFFF);

        // R8: write while disabled after reset
        prog(2'b01, 8'h03, 16'h1234, 1'b1, 1'b0);
        cs_up();
        check(do_oe == 1'b0, "R8 no busy when disabled", 32'(do_oe), 0);
        cs_down();
        chk_word(8'h03, 16'hFFFF, "R8 word unchanged");

        // R12: enable cancelled by extra clock
        prog(2'b00, 8'hC0, 16'h0, 1'b0, 1'b1);
        prog(2'b01, 8'h03, 16'h1234, 1'b1, 1'b0);
        wait_n(PROG + 20);
        chk_word(8'h03, 16'hFFFF, "R12 cancelled enable");

        // R4/R5/R3: enable, sweep writes then reads with flipped address MSB
        prog(2'b00, 8'hC5, 16'h0, 1'b0, 1'b0);
        for (int a = 0; a < 128; a++) begin
            prog(2'b01, {a[0], 7'(a)}, pat(a), 1'b1, 1'b0);
            wait_n(PROG + 20);
        end
        for (int a = 0; a < 128; a++)
            chk_word({~a[0], 7'(a)}, pat(a), "R5 R3 write/read sweep");

        // R6: erase one word
        prog(2'b11, 8'h85, 16'h0, 1'b0, 1'b0);
        wait_n(PROG + 20);
        chk_word(8'h05, 16'hFFFF, "R6 erased word");
        chk_word(8'h04, pat(4), "R6 neighbour kept");

        // R9/R10/R11/R13: busy and ready status
        prog(2'b01, 8'h0A, 16'hBEEF, 1'b1, 1'b0);
        cs_up();
        check(do_oe == 1'b1 && do_o == 1'b0, "R9 busy shown", 32'({do_oe, do_o}), 32'b10);
        send({5'd0, 1'b1, 2'b01, 8'h0B, 16'h0000}, 27);
        check(do_oe == 1'b1 && do_o == 1'b0, "R11 R9 still busy", 32'({do_oe, do_o}), 32'b10);
        cs_down();
        check(do_oe == 1'b0, "R13 hiz when deselected", 32'(do_oe), 0);
        cs_up();
        wait_n(PROG + 20);
        check(do_oe == 1'b1 && do_o == 1'b1, "R9 ready shown", 32'({do_oe, do_o}), 32'b11);
        cs_down();
        cs_up();
        check(do_oe == 1'b1 && do_o == 1'b1, "R10 ready kept over cs toggle", 32'({do_oe, do_o}), 32'b11);
        sk_bit(1'b0, r);
        check(last_oe == 1'b1 && r == 1'b1, "R10 zero keeps ready", 32'({last_oe, r}), 32'b11);
        sk_bit(1'b1, r);
        check(last_oe == 1'b0, "R10 start bit clears status", 32'(last_oe), 0);
        rd(8'h0A, 1'b0, got);
        check(got == {1'b0, 16'hBEEF}, "R10 start bit begins read", 32'(got), 32'h0BEEF);
        chk_word(8'h0B, pat(11), "R11 ignored while busy");

        // R4/R8: disable then write ignored
        prog(2'b00, 8'h3F, 16'h0, 1'b0, 1'b0);
        prog(2'b01, 8'h06, 16'h0000, 1'b1, 1'b0);
        cs_up();
        check(do_oe == 1'b0, "R4 R8 disabled write no busy", 32'(do_oe), 0);
        cs_down();
        chk_word(8'h06, pat(6), "R4 R8 word kept after disable");

        // R7: write all, erase all
        prog(2'b00, 8'hC0, 16'h0, 1'b0, 1'b0);
        prog(2'b00, 8'h40, 16'hC3A5, 1'b1, 1'b0);
        wait_n(PROG + 20);
        for (int a = 0; a < 128; a++) chk_word(8'(a), 16'hC3A5, "R7 write all");
        prog(2'b00, 8'h80, 16'h0, 1'b0, 1'b0);
        wait_n(PROG + 20);
        for (int a = 0; a < 128; a++) chk_word(8'(a), 16'hFFFF, "R7 erase all");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule